// File: doc/BRIEF.md
# Console Device Register Page

This block answers for the top page of a 16-bit processor's address space, 0xFE00 through 0xFFFF. Inside that page it holds five device registers: status and data for a keyboard, status and data for a character display, and a machine control word that carries the processor's run latch. The processor reaches them with plain reads and writes on its memory bus. The block asserts `busSel` so that the memory system can drop those cycles.

The status flags are not written directly. Each one moves as a side effect of traffic on a data register. A byte arriving from the keyboard sets the keyboard ready flag, and a processor read of the keyboard data register clears it. A processor write to the display data register clears the display done flag and offers the byte to the display. The display accepting that byte sets done again. Each device raises its interrupt request only while its flag and its enable bit are both set. Writing 0 to the run bit stops the processor.

Top module: `console_io_regs`

## Requirements
- R1: `busSel` is high exactly when `busAddr` lies in 0xFE00..0xFFFF. `busRdData` is zero when `busRd` is low, and it is zero for a read of any address other than 0xFE00, 0xFE02, 0xFE04, 0xFE06 and 0xFFFE.
- R2: After reset the keyboard status (0xFE00) reads 0x0000 and the display status (0xFE04) reads 0x8000. The control word (0xFFFE) reads 0x8000 and `runEn` is 1. Both interrupt requests are 0 and `dispValid` is 0.
- R3: A cycle with `kbdValid` high makes 0xFE00 bit 15 read 1 from the next cycle on, and makes 0xFE02 read the byte in bits 7:0 with bits 15:8 zero.
- R4: A read of 0xFE02 clears keyboard ready in the next cycle. If `kbdValid` is high in the same cycle, ready stays 1 and the new byte is kept.
- R5: A write to 0xFE06 stores bits 7:0, clears display done (0xFE04 bit 15) and drives `dispValid` high with that byte on `dispByte`. A cycle with `dispValid` and `dispAccept` both high sets done and drops `dispValid`. If the write and the accept fall in the same cycle, the write wins. 0xFE06 reads back the stored byte.
- R6: At 0xFE00 and 0xFE04 only bit 14, the interrupt enable, is writable. Bit 15 ignores writes, and every other bit reads 0.
- R7: `kbdIrq` is high exactly while keyboard ready and its enable are both 1. `dispIrq` is high exactly while display done and its enable are both 1.
- R8: A write to 0xFFFE loads bit 15 into the run latch, which drives `runEn`. All other bits of that word read 0.
- R9: Writes to any address other than the five registers change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Processor address |
| busWrData | input | 16 | Processor write data |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busRdData | output | 16 | Read data, combinational |
| busSel | output | 1 | Address falls in the device page |
| kbdByte | input | 8 | Received keyboard character |
| kbdValid | input | 1 | `kbdByte` is valid this cycle |
| dispByte | output | 8 | Character offered to the display |
| dispValid | output | 1 | A character is waiting for the display |
| dispAccept | input | 1 | The display takes the waiting character |
| kbdIrq | output | 1 | Keyboard interrupt request |
| dispIrq | output | 1 | Display interrupt request |
| runEn | output | 1 | Processor run latch |

## Verification
The assertions assume that `busRd` and `busWr` are never high in the same cycle. They also assume that the keyboard presents a byte as a single cycle of `kbdValid`, whether or not the previous byte has been read. The random stimulus picks at most one bus operation per cycle, either a read or a write. It pulses `kbdValid` and `dispAccept` independently and aims at a short list of addresses that covers every register, unused offsets inside the page and one address outside it. Directed steps force the two same-cycle collisions: a keyboard read with a byte arriving, and a display write with an accept.

// File: rtl/console_io_pkg.sv
package console_io_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam int PAGE_LSB = 9;

  localparam logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00;
  localparam logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02;
  localparam logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04;
  localparam logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 16'hFFFE;

  localparam int FLAG_BIT = 15;
  localparam int IE_BIT   = 14;
  localparam int RUN_BIT  = 15;

  typedef enum logic [2:0] {
    RD_NONE, RD_KSTAT, RD_KDATA, RD_DSTAT, RD_DDATA, RD_CTRL
  } rdSel_e;

  typedef struct packed {
    logic   kStatWr;
    logic   kDataRd;
    logic   dStatWr;
    logic   dDataWr;
    logic   ctrlWr;
    rdSel_e rdSel;
  } ioStrobes_t;
endpackage

// File: rtl/console_io_ctrl.sv
module console_io_ctrl
  import console_io_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busRd,
  input  logic          busWr,
  output logic          busSel,
  output ioStrobes_t    strobes
);
  localparam int PAGE_W = AW - PAGE_LSB;

  logic inPage;
  rdSel_e hit;

  assign inPage = (busAddr[AW-1:PAGE_LSB] == {PAGE_W{1'b1}});
  assign busSel = inPage;

  always_comb begin
    hit = RD_NONE;
    if (inPage) begin
      case (busAddr)
        KSTAT_ADDR: hit = RD_KSTAT;
        KDATA_ADDR: hit = RD_KDATA;
        DSTAT_ADDR: hit = RD_DSTAT;
        DDATA_ADDR: hit = RD_DDATA;
        CTRL_ADDR:  hit = RD_CTRL;
        default:    hit = RD_NONE;
      endcase
    end
  end

  always_comb begin
    strobes.kStatWr = busWr && (hit == RD_KSTAT);
    strobes.kDataRd = busRd && (hit == RD_KDATA);
    strobes.dStatWr = busWr && (hit == RD_DSTAT);
    strobes.dDataWr = busWr && (hit == RD_DDATA);
    strobes.ctrlWr  = busWr && (hit == RD_CTRL);
    strobes.rdSel   = busRd ? hit : RD_NONE;
  end
endmodule

// File: rtl/console_io_dpath.sv
module console_io_dpath
  import console_io_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ioStrobes_t    strobes,
  input  logic [DW-1:0] busWrData,
  output logic [DW-1:0] busRdData,
  input  logic [CW-1:0] kbdByte,
  input  logic          kbdValid,
  output logic [CW-1:0] dispByte,
  output logic          dispValid,
  input  logic          dispAccept,
  output logic          kbdIrq,
  output logic          dispIrq,
  output logic          runEn,
  output logic          kbdReady,
  output logic          dispDone
);
  localparam int PAD_W = DW - CW;

  logic          kbdIe;
  logic          dispIe;
  logic          runLatch;
  logic [CW-1:0] kbdData;
  logic [CW-1:0] dispData;

  // Keyboard side: a new byte wins over a clearing read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdReady <= 1'b0;
      kbdData  <= '0;
    end else if (kbdValid) begin
      kbdReady <= 1'b1;
      kbdData  <= kbdByte;
    end else if (strobes.kDataRd) begin
      kbdReady <= 1'b0;
    end
  end

  // Display side: a new write wins over an accept.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispDone <= 1'b1;
      dispData <= '0;
    end else if (strobes.dDataWr) begin
      dispDone <= 1'b0;
      dispData <= busWrData[CW-1:0];
    end else if (!dispDone && dispAccept) begin
      dispDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdIe    <= 1'b0;
      dispIe   <= 1'b0;
      runLatch <= 1'b1;
    end else begin
      if (strobes.kStatWr) kbdIe    <= busWrData[IE_BIT];
      if (strobes.dStatWr) dispIe   <= busWrData[IE_BIT];
      if (strobes.ctrlWr)  runLatch <= busWrData[RUN_BIT];
    end
  end

  always_comb begin
    busRdData = '0;
    case (strobes.rdSel)
      RD_KSTAT: begin
        busRdData[FLAG_BIT] = kbdReady;
        busRdData[IE_BIT]   = kbdIe;
      end
      RD_KDATA: busRdData = {{PAD_W{1'b0}}, kbdData};
      RD_DSTAT: begin
        busRdData[FLAG_BIT] = dispDone;
        busRdData[IE_BIT]   = dispIe;
      end
      RD_DDATA: busRdData = {{PAD_W{1'b0}}, dispData};
      RD_CTRL:  busRdData[RUN_BIT] = runLatch;
      default:  busRdData = '0;
    endcase
  end

  assign dispByte  = dispData;
  assign dispValid = !dispDone;
  assign kbdIrq    = kbdReady & kbdIe;
  assign dispIrq   = dispDone & dispIe;
  assign runEn     = runLatch;
endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
  import console_io_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [DATA_W-1:0] busRdData,
  output logic              busSel,
  input  logic [CHAR_W-1:0] kbdByte,
  input  logic              kbdValid,
  output logic [CHAR_W-1:0] dispByte,
  output logic              dispValid,
  input  logic              dispAccept,
  output logic              kbdIrq,
  output logic              dispIrq,
  output logic              runEn
);
  ioStrobes_t strobes;
  logic       kbdReady;
  logic       dispDone;

  console_io_ctrl #(.AW(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busSel  (busSel),
    .strobes (strobes)
  );

  console_io_dpath #(.DW(DATA_W), .CW(CHAR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .kbdByte    (kbdByte),
    .kbdValid   (kbdValid),
    .dispByte   (dispByte),
    .dispValid  (dispValid),
    .dispAccept (dispAccept),
    .kbdIrq     (kbdIrq),
    .dispIrq    (dispIrq),
    .runEn      (runEn),
    .kbdReady   (kbdReady),
    .dispDone   (dispDone)
  );
endmodule

// File: rtl/console_io_chk.sv
module console_io_chk
  import console_io_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRd,
  input logic              busWr,
  input logic              busSel,
  input logic [CHAR_W-1:0] kbdByte,
  input logic              kbdValid,
  input logic [CHAR_W-1:0] dispByte,
  input logic              dispValid,
  input logic              dispAccept,
  input logic              kbdIrq,
  input logic              runEn,
  input logic              kbdReady
);
  logic kDataRead;
  logic dDataWrite;
  logic ctrlWrite;
  assign kDataRead  = busRd && (busAddr == KDATA_ADDR);
  assign dDataWrite = busWr && (busAddr == DDATA_ADDR);
  assign ctrlWrite  = busWr && (busAddr == CTRL_ADDR);

  p_sel_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    busSel == (busAddr >= KSTAT_ADDR));

  p_kbd_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    kbdValid |=> kbdReady);

  p_kbd_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (kDataRead && !kbdValid) |=> !kbdReady && !kbdIrq);

  p_disp_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    dDataWrite |=> dispValid && (dispByte == $past(busWrData[CHAR_W-1:0])));

  p_disp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispAccept && !dDataWrite) |=> dispValid && $stable(dispByte));

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    kbdIrq |-> kbdReady);

  p_run_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> runEn == $past(busWrData[RUN_BIT]));

  p_run_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(runEn));

  p_no_collision: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
endmodule

bind console_io_regs console_io_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .busRd      (busRd),
  .busWr      (busWr),
  .busSel     (busSel),
  .kbdByte    (kbdByte),
  .kbdValid   (kbdValid),
  .dispByte   (dispByte),
  .dispValid  (dispValid),
  .dispAccept (dispAccept),
  .kbdIrq     (kbdIrq),
  .runEn      (runEn),
  .kbdReady   (kbdReady)
);

// File: tb/test_console_io_regs.sv
`timescale 1ns/100ps
module test_console_io_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busRdData;
  logic        busSel;
  logic [7:0]  kbdByte = '0;
  logic        kbdValid = 1'b0;
  logic [7:0]  dispByte;
  logic        dispValid;
  logic        dispAccept = 1'b0;
  logic        kbdIrq;
  logic        dispIrq;
  logic        runEn;

  int total = 0;
  int bad = 0;

  // Reference state
  logic       mKr = 1'b0, mKie = 1'b0, mDd = 1'b1, mDie = 1'b0, mRun = 1'b1;
  logic [7:0] mKd = '0, mDb = '0;

  always #2.5 clk = ~clk;

  console_io_regs i_console_io_regs (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(logic [15:0] a);
    case (a)
      16'hFE00: return {mKr, mKie, 14'b0};
      16'hFE02: return {8'b0, mKd};
      16'hFE04: return {mDd, mDie, 14'b0};
      16'hFE06: return {8'b0, mDb};
      16'hFFFE: return {mRun, 15'b0};
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic string regTag(logic [15:0] a);
    case (a)
      16'hFE00, 16'hFE04: return "R6";
      16'hFE02: return "R3";
      16'hFE06: return "R5";
      16'hFFFE: return "R8";
      default:  return "R1";
    endcase
  endfunction

  // One bus cycle: drive after the falling edge, check the read path, then the
  // registered outputs after the next rising edge.
  task automatic step(logic rd, logic wr, logic [15:0] a, logic [15:0] wd,
                      logic kv, logic [7:0] kb, logic acc);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busWrData = wd;
    kbdValid = kv; kbdByte = kb; dispAccept = acc;
    #1;
    check("R1 sel", {15'b0, busSel}, {15'b0, a >= 16'hFE00});
    check(rd ? regTag(a) : "R1", busRdData, rd ? expRead(a) : 16'h0000);
    if (kv) begin mKr = 1'b1; mKd = kb; end
    else if (rd && a == 16'hFE02) mKr = 1'b0;
    if (wr && a == 16'hFE00) mKie = wd[14];
    if (wr && a == 16'hFE04) mDie = wd[14];
    if (wr && a == 16'hFE06) begin mDd = 1'b0; mDb = wd[7:0]; end
    else if (!mDd && acc) mDd = 1'b1;
    if (wr && a == 16'hFFFE) mRun = wd[15];
    @(posedge clk);
    #1;
    check("R7 kbdIrq", {15'b0, kbdIrq}, {15'b0, mKr & mKie});
    check("R7 dispIrq", {15'b0, dispIrq}, {15'b0, mDd & mDie});
    check("R5 valid", {15'b0, dispValid}, {15'b0, !mDd});
    check("R5 byte", {8'b0, dispByte}, {8'b0, mDb});
    check("R8 run", {15'b0, runEn}, {15'b0, mRun});
  endtask

  localparam logic [15:0] ADDRS [8] = '{16'hFE00, 16'hFE02, 16'hFE04, 16'hFE06,
                                        16'hFFFE, 16'hFE08, 16'hFF00, 16'h3000};

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1F2E;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state, seen at the ports while reset is held
    check("R2 kbdIrq", {15'b0, kbdIrq}, 16'h0);
    check("R2 dispIrq", {15'b0, dispIrq}, 16'h0);
    check("R2 dispValid", {15'b0, dispValid}, 16'h0);
    check("R2 runEn", {15'b0, runEn}, 16'h1);
    @(negedge clk); rstN = 1'b1;
    step(1, 0, 16'hFE00, 0, 0, 0, 0);   // R2 kstat 0000
    step(1, 0, 16'hFE04, 0, 0, 0, 0);   // R2 dstat 8000
    step(1, 0, 16'hFFFE, 0, 0, 0, 0);   // R2 ctrl 8000
    // R6: try to write status flags; only enables stick
    step(0, 1, 16'hFE00, 16'hFFFF, 0, 0, 0);
    step(1, 0, 16'hFE00, 0, 0, 0, 0);
    step(0, 1, 16'hFE04, 16'h7FFF, 0, 0, 0);
    step(1, 0, 16'hFE04, 0, 0, 0, 0);
    // R3/R4: arrival, read clears, read with arrival keeps ready
    step(0, 0, 16'h0000, 0, 1, 8'h41, 0);
    step(1, 0, 16'hFE02, 0, 0, 0, 0);
    step(1, 0, 16'hFE02, 0, 1, 8'h42, 0);
    step(1, 0, 16'hFE00, 0, 0, 0, 0);
    // R5: write, accept, then write colliding with accept
    step(0, 1, 16'hFE06, 16'h1234, 0, 0, 0);
    step(0, 0, 16'h0000, 0, 0, 0, 1);
    step(0, 1, 16'hFE06, 16'h0055, 0, 0, 0);
    step(0, 1, 16'hFE06, 16'h00AA, 0, 0, 1);
    step(1, 0, 16'hFE04, 0, 0, 0, 0);
    // R9: writes to unused addresses change nothing
    step(0, 1, 16'hFE08, 16'hFFFF, 0, 0, 0);
    step(0, 1, 16'h3000, 16'h0000, 0, 0, 0);
    step(1, 0, 16'hFE06, 0, 0, 0, 0);
    // R8: halt and restart
    step(0, 1, 16'hFFFE, 16'h7FFF, 0, 0, 0);
    step(1, 0, 16'hFFFE, 0, 0, 0, 0);
    step(0, 1, 16'hFFFE, 16'h8000, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      int op;
      op = $urandom_range(0, 3);
      step(op == 1, op == 2, ADDRS[$urandom_range(0, 7)], 16'($urandom),
           $urandom_range(0, 5) == 0, 8'($urandom), $urandom_range(0, 2) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule